// File: doc/BRIEF.md
# Third-Order Decimating Filter with Serial Word Formatting

This block turns a one-bit oversampled bitstream into 15-bit two's-complement samples and packs each sample into a 16-bit word ready for a serial transfer. Input bits arrive with a one-cycle enable, nominally once every eight master clocks. A bit of 1 counts as +1 and a bit of 0 counts as -1. Three wrap-around accumulators feed three differencing stages with a differential delay of 32. Together they form the response ((1 - z^-32)/(1 - z^-1))^3, so one result word is produced for every 32 enables.

The filter's DC gain of 2^15 is scaled away so that a stream of all ones reaches positive full scale. A static mode input selects the output packing. In 16-bit data packing, the 15-bit sample fills the upper bits and the lowest bit is zero, except that a positive full-scale input gives 0x7FFF. In flagged packing, the 15-bit sample fills the lower bits and the top bit is a frame flag, driven to 0 to mark a data frame. A synchronous reset clears all filter state. The first few words after reset are settling values.

Top module: `sinc3_decimator`

## Requirements
- R1: While reset is high, and on the cycle after it, out_valid is 0 and out_word is 0x0000.
- R2: out_valid is a one-cycle pulse, and exactly 32 accepted input enables separate consecutive pulses.
- R3: In 16-bit data packing (mode_mixed = 0), a steady all-ones input gives out_word = 0x7FFF.
- R4: In 16-bit data packing, a non-saturated sample S (15 bits) appears as {S, 0}. A 75 % ones density gives 0x4000.
- R5: A steady all-zeros input gives 0x8000 in data packing and 0x4000 in flagged packing.
- R6: In flagged packing (mode_mixed = 1), bit 15 is 0 (the data flag) and bits 14:0 carry S. A 75 % ones density gives 0x2000.
- R7: In flagged packing, a steady all-ones input saturates to 0x3FFF.
- R8: An input alternating 1,0 gives a word of 0x0000, because bit 1 maps to +1 and bit 0 maps to -1.
- R9: A 25 % ones density gives 0xC000 in data packing and 0x6000 in flagged packing.
- R10: in_bit has no effect on any cycle where in_en is 0.
- R11: After a reset, the first out_valid pulse follows the 32nd accepted enable.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| in_en | input | 1 | Qualifies in_bit for one cycle |
| in_bit | input | 1 | Bitstream sample: 1 counts as +1, 0 counts as -1 |
| mode_mixed | input | 1 | Static packing select: 0 = 16-bit data, 1 = flagged 15-bit |
| out_word | output | 16 | Packed result word |
| out_valid | output | 1 | One-cycle strobe marking a new out_word |

## Verification
The hardest case to reach is the single exact full-scale code. Only a stream of all ones drives the filter to +2^15, and it gets there only after the differencing delays have filled, which takes several output words. The bench therefore holds each density pattern from a fresh reset, discards the settling words and compares words five and six. On every cycle without an enable it also drives in_bit to the inverse of the real sample, so any leak of in_bit past the enable corrupts the checked values.

// File: rtl/cic_dec_pkg.sv
package cic_dec_pkg;
  typedef enum logic {
    FMT_DATA16  = 1'b0,
    FMT_MIXED15 = 1'b1
  } fmt_mode_e;

  localparam logic FRAME_FLAG_DATA = 1'b0;
endpackage

// File: rtl/cic_integ.sv
module cic_integ #(
  parameter int ORDER = 3,
  parameter int ACC_W = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    en,
  input  logic                    bit_in,
  output logic signed [ACC_W-1:0] acc_o
);
  logic signed [ACC_W-1:0] stg [ORDER];
  logic signed [ACC_W-1:0] x;

  // +1 for a one, -1 for a zero
  assign x = bit_in ? ACC_W'(1) : {ACC_W{1'b1}};

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk) begin
        if (rst)     stg[g] <= '0;
        else if (en) stg[g] <= stg[g] + x;
      end
    end else begin : g_next
      always_ff @(posedge clk) begin
        if (rst)     stg[g] <= '0;
        else if (en) stg[g] <= stg[g] + stg[g-1];
      end
    end
  end

  assign acc_o = stg[ORDER-1];
endmodule

// File: rtl/cic_decim_ctr.sv
module cic_decim_ctr #(
  parameter int RATE = 32
) (
  input  logic clk,
  input  logic rst,
  input  logic en,
  output logic stb_o
);
  localparam int CW = (RATE > 1) ? $clog2(RATE) : 1;
  localparam logic [CW-1:0] LAST = CW'(RATE - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      stb_o <= 1'b0;
    end else begin
      stb_o <= en && (cnt == LAST);
      if (en) cnt <= (cnt == LAST) ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/cic_comb.sv
module cic_comb #(
  parameter int ORDER = 3,
  parameter int ACC_W = 17
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    stb,
  input  logic signed [ACC_W-1:0] din,
  output logic signed [ACC_W-1:0] y_o,
  output logic                    vld_o
);
  logic signed [ACC_W-1:0] dly  [ORDER];
  logic signed [ACC_W-1:0] diff [ORDER+1];

  assign diff[0] = din;

  for (genvar g = 0; g < ORDER; g++) begin : g_stage
    assign diff[g+1] = diff[g] - dly[g];
    always_ff @(posedge clk) begin
      if (rst)      dly[g] <= '0;
      else if (stb) dly[g] <= diff[g];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      y_o   <= '0;
      vld_o <= 1'b0;
    end else begin
      vld_o <= stb;
      if (stb) y_o <= diff[ORDER];
    end
  end
endmodule

// File: rtl/cic_fmt.sv
module cic_fmt
  import cic_dec_pkg::*;
#(
  parameter int ACC_W = 17,
  parameter int OUT_W = 15,
  parameter int SHIFT = 1
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    vld,
  input  logic signed [ACC_W-1:0] y,
  input  fmt_mode_e               mode,
  output logic [OUT_W:0]          word_o,
  output logic                    valid_o
);
  localparam logic signed [ACC_W-1:0] MAXPOS = ACC_W'((1 << (OUT_W - 1)) - 1);

  logic signed [ACC_W-1:0] y_sh;
  logic                    sat;
  logic [OUT_W-1:0]        smp;
  logic [OUT_W:0]          packed_w;

  assign y_sh = y >>> SHIFT;
  assign sat  = (y_sh > MAXPOS);
  assign smp  = sat ? MAXPOS[OUT_W-1:0] : y_sh[OUT_W-1:0];

  always_comb begin
    if (mode == FMT_MIXED15)
      packed_w = {FRAME_FLAG_DATA, smp};
    else if (sat)
      packed_w = {1'b0, {OUT_W{1'b1}}};
    else
      packed_w = {smp, 1'b0};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      word_o  <= '0;
      valid_o <= 1'b0;
    end else begin
      valid_o <= vld;
      if (vld) word_o <= packed_w;
    end
  end
endmodule

// File: rtl/sinc3_decimator.sv
module sinc3_decimator
  import cic_dec_pkg::*;
#(
  parameter int ORDER = 3,
  parameter int RATE  = 32,
  parameter int OUT_W = 15
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             in_en,
  input  logic             in_bit,
  input  logic             mode_mixed,
  output logic [OUT_W:0]   out_word,
  output logic             out_valid
);
  localparam int GROWTH = ORDER * $clog2(RATE);
  localparam int ACC_W  = GROWTH + 2;
  localparam int SHIFT  = GROWTH - (OUT_W - 1);

  logic signed [ACC_W-1:0] acc;
  logic signed [ACC_W-1:0] comb_y;
  logic                    dec_stb;
  logic                    comb_vld;
  fmt_mode_e               mode;

  assign mode = fmt_mode_e'(mode_mixed);

  cic_integ #(.ORDER(ORDER), .ACC_W(ACC_W)) u_integ (
    .clk(clk), .rst(rst), .en(in_en), .bit_in(in_bit), .acc_o(acc)
  );

  cic_decim_ctr #(.RATE(RATE)) u_ctr (
    .clk(clk), .rst(rst), .en(in_en), .stb_o(dec_stb)
  );

  cic_comb #(.ORDER(ORDER), .ACC_W(ACC_W)) u_comb (
    .clk(clk), .rst(rst), .stb(dec_stb), .din(acc),
    .y_o(comb_y), .vld_o(comb_vld)
  );

  cic_fmt #(.ACC_W(ACC_W), .OUT_W(OUT_W), .SHIFT(SHIFT)) u_fmt (
    .clk(clk), .rst(rst), .vld(comb_vld), .y(comb_y), .mode(mode),
    .word_o(out_word), .valid_o(out_valid)
  );
endmodule

// File: rtl/cic_dec_chk.sv
module cic_dec_chk #(
  parameter int RATE = 32
) (
  input logic        clk,
  input logic        rst,
  input logic        in_en,
  input logic        mode_mixed,
  input logic [15:0] out_word,
  input logic        out_valid
);
  logic [15:0] gap;

  always_ff @(posedge clk) begin
    if (rst)            gap <= '0;
    else if (out_valid) gap <= in_en ? 16'd1 : 16'd0;
    else if (in_en)     gap <= gap + 16'd1;
  end

  p_pulse_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |=> !out_valid);

  p_spacing_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> (gap == 16'(RATE)));

  p_lsb_r4: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !mode_mixed) |-> (!out_word[0] || out_word == 16'h7FFF));

  p_flag_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_mixed) |-> !out_word[15]);

  p_sat_r7: assert property (@(posedge clk) disable iff (rst)
    (out_valid && mode_mixed) |-> (out_word != 16'h7FFF));
endmodule

bind sinc3_decimator cic_dec_chk #(.RATE(RATE)) u_chk (
  .clk(clk), .rst(rst), .in_en(in_en), .mode_mixed(mode_mixed),
  .out_word(out_word), .out_valid(out_valid)
);

// File: tb/sinc3_decimator_bench.sv
`timescale 1ns/1ps
module sinc3_decimator_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_en = 1'b0;
  logic        in_bit = 1'b0;
  logic        mode_mixed = 1'b0;
  logic [15:0] out_word;
  logic        out_valid;

  int checks = 0;
  int failures = 0;
  bit finished = 1'b0;

  always #4 clk = ~clk;

  sinc3_decimator u_sinc3_decimator (
    .clk(clk), .rst(rst), .in_en(in_en), .in_bit(in_bit),
    .mode_mixed(mode_mixed), .out_word(out_word), .out_valid(out_valid)
  );

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  // R1: reset clears output; also applies the static mode
  task automatic do_reset(input logic mixed);
    @(negedge clk);
    rst = 1'b1; in_en = 1'b0; mode_mixed = mixed;
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0 && out_word == 16'h0000, "R1 during reset",
          {out_valid, out_word}, 0);
    rst = 1'b0;
    @(negedge clk);
    check(out_valid == 1'b0 && out_word == 16'h0000, "R1 after reset",
          {out_valid, out_word}, 0);
  endtask

  // One density pattern from reset; words 5 and 6 are compared.
  task automatic run_case(input logic [3:0] pat, input logic mixed,
                          input logic [15:0] exp, input string tag);
    int words = 0;
    int en_cnt = 0;
    int k = 0;
    bit prev_v = 1'b0;
    bit width_ok = 1'b1;
    do_reset(mixed);
    while (words < 6 && !finished) begin
      for (int c = 0; c < 8; c++) begin
        @(negedge clk);
        if (prev_v && out_valid) width_ok = 1'b0;
        prev_v = out_valid;
        if (out_valid) begin
          if (words == 0)
            check(en_cnt == 32, "R11 first word after reset", en_cnt, 32);
          else if (words == 1)
            check(en_cnt == 32, "R2 enables between words", en_cnt, 32);
          else if (words >= 4)
            check(out_word == exp, {tag, " R10 value"}, out_word, exp);
          words++;
          en_cnt = 0;
        end
        if (c == 0) begin
          in_en = 1'b1;
          in_bit = pat[k % 4];
          k++;
          en_cnt++;
        end else begin
          in_en = 1'b0;
          in_bit = ~pat[(k - 1) % 4];
        end
      end
    end
    check(width_ok, "R2 strobe width", 0, 1);
  endtask

  initial begin
    do_reset(1'b0);
    run_case(4'b1111, 1'b0, 16'h7FFF, "R3 full scale data");
    run_case(4'b1111, 1'b1, 16'h3FFF, "R7 full scale flagged");
    run_case(4'b0000, 1'b0, 16'h8000, "R5 zeros data");
    run_case(4'b0000, 1'b1, 16'h4000, "R5 zeros flagged");
    run_case(4'b0111, 1'b0, 16'h4000, "R4 three quarter data");
    run_case(4'b0111, 1'b1, 16'h2000, "R6 three quarter flagged");
    run_case(4'b0001, 1'b0, 16'hC000, "R9 quarter data");
    run_case(4'b0001, 1'b1, 16'h6000, "R9 quarter flagged");
    run_case(4'b0101, 1'b0, 16'h0000, "R8 alternating");
    if (!finished) begin
      finished = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    #(8 * 190000);
    if (!finished) begin
      finished = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule